// File: doc/BRIEF.md
# Operand Decode and Register Stage

This block is the decode stage of a small 32-bit load/store processor. It takes an instruction word and splits out two source register numbers, a destination register number and a 16-bit immediate. It reads both source registers from a 32-entry by 32-bit register file and produces the two ALU operands. A control input chooses which instruction field names the destination. A second control input chooses whether the second operand comes from a register or from the sign-extended immediate.

The block also contains the write port of the register file, which the writeback stage drives with an enable, an address and data. The read ports are combinational. A write takes effect at the rising clock edge, so a read of the register being written in the same cycle still returns the old contents. Register 0 is hard-wired to zero. The control signals come from an opcode decoder outside this block.

Top module: `operand_decode_stage`

## Requirements
- R1: `op_a` equals the contents of the register numbered by instruction bits [25:21].
- R2: `store_data` equals the contents of the register numbered by instruction bits [20:16], whatever `imm_sel` is.
- R3: `dst_reg` equals instruction bits [20:16] when `dst_sel` is 0, and bits [15:11] when `dst_sel` is 1.
- R4: `imm_ext` equals instruction bits [15:0] in its low half, with bit 15 copied into all of bits [31:16].
- R5: `op_b` equals `store_data` when `imm_sel` is 0 and `imm_ext` when `imm_sel` is 1.
- R6: A register changes only at a rising clock edge where `wr_en` is 1 and `wr_addr` names it. It then holds `wr_data`. When `wr_en` is 0, every register keeps its value.
- R7: Register 0 always reads as zero. A write addressed to it leaves it at zero.
- R8: In the cycle of a write, a read of the target register returns the value it had before. The new value appears on the read outputs after the rising edge.
- R9: While `rst_n` is low, all registers are zero. The clear is applied asynchronously and released at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word being decoded |
| dst_sel | input | 1 | Destination field select: 0 = bits [20:16], 1 = bits [15:11] |
| imm_sel | input | 1 | Second operand select: 0 = register, 1 = immediate |
| wr_en | input | 1 | Register write enable from writeback |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Data to write |
| op_a | output | 32 | First ALU operand |
| op_b | output | 32 | Second ALU operand |
| store_data | output | 32 | Raw second register value, used for stores |
| imm_ext | output | 32 | Sign-extended immediate |
| dst_reg | output | 5 | Destination register number |

## Verification
The hardest case to reach from the ports is the window in which a register is being written while the same register is being read. It lasts only from the moment the write is set up until the next rising edge. The bench drives a write and an instruction that reads the target register together at the falling edge. It samples the operand before the rising edge, where the old value is expected, and again after it, where the new value is expected. Writes to register 0 and writes with the enable low are checked by reading the addressed register back through the operand outputs.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int RAW     = $clog2(NREG);
  localparam int IMM_W   = 16;
  localparam int SRC1_LO = 21;
  localparam int SRC2_LO = 16;
  localparam int DST_LO  = 11;

  typedef logic [RAW-1:0]  reg_idx_t;
  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    reg_idx_t src1;
    reg_idx_t src2;
    reg_idx_t dst_alt;
    logic [IMM_W-1:0] imm;
  } fields_t;
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import dec_pkg::*;
(
  input  word_t   instr,
  output fields_t flds,
  output word_t   imm_ext
);
  always_comb begin
    flds.src1    = instr[SRC1_LO +: RAW];
    flds.src2    = instr[SRC2_LO +: RAW];
    flds.dst_alt = instr[DST_LO  +: RAW];
    flds.imm     = instr[IMM_W-1:0];
  end

  assign imm_ext = {{(XLEN-IMM_W){flds.imm[IMM_W-1]}}, flds.imm};
endmodule

// File: rtl/dec_regfile.sv
module dec_regfile
  import dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  reg_idx_t wr_addr,
  input  word_t    wr_data,
  input  reg_idx_t rd_addr_a,
  input  reg_idx_t rd_addr_b,
  output word_t    rd_data_a,
  output word_t    rd_data_b
);
  word_t regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      logic  ce;
      word_t nxt;

      always_comb begin
        ce  = wr_en && (wr_addr == reg_idx_t'(i));
        nxt = ce ? wr_data : regs[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else        regs[i] <= nxt;
      end

      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == reg_idx_t'(i)) |=> $stable(regs[i]));
      p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == reg_idx_t'(i)) |=> regs[i] == $past(wr_data));
    end
  end

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];
endmodule

// File: rtl/dec_opsel.sv
module dec_opsel
  import dec_pkg::*;
(
  input  logic     dst_sel,
  input  logic     imm_sel,
  input  fields_t  flds,
  input  word_t    reg_b,
  input  word_t    imm_ext,
  output word_t    op_b,
  output reg_idx_t dst_reg
);
  always_comb begin
    op_b    = imm_sel ? imm_ext : reg_b;
    dst_reg = dst_sel ? flds.dst_alt : flds.src2;
  end
endmodule

// File: rtl/operand_decode_stage.sv
module operand_decode_stage
  import dec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic        dst_sel,
  input  logic        imm_sel,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] op_a,
  output logic [31:0] op_b,
  output logic [31:0] store_data,
  output logic [31:0] imm_ext,
  output logic [4:0]  dst_reg
);
  fields_t flds;
  word_t   imm_w;
  word_t   rd_a;
  word_t   rd_b;

  dec_fields u_fields (
    .instr   (instr),
    .flds    (flds),
    .imm_ext (imm_w)
  );

  dec_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (flds.src1),
    .rd_addr_b (flds.src2),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  dec_opsel u_opsel (
    .dst_sel (dst_sel),
    .imm_sel (imm_sel),
    .flds    (flds),
    .reg_b   (rd_b),
    .imm_ext (imm_w),
    .op_b    (op_b),
    .dst_reg (dst_reg)
  );

  assign op_a       = rd_a;
  assign store_data = rd_b;
  assign imm_ext    = imm_w;

  p_zero_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> (op_a == 32'd0));
  p_zero_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[20:16] == 5'd0) |-> (store_data == 32'd0));
  p_dst_rt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_sel |-> (dst_reg == instr[20:16]));
  p_dst_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_sel |-> (dst_reg == instr[15:11]));
  p_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_ext[31:16] == {16{instr[15]}}) && (imm_ext[15:0] == instr[15:0]));
  p_opb_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |-> (op_b == imm_ext));
  p_opb_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !imm_sel |-> (op_b == store_data));
endmodule

// File: tb/test_operand_decode_stage.sv
module test_operand_decode_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        dst_sel, imm_sel, wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] op_a, op_b, store_data, imm_ext;
  logic [4:0]  dst_reg;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  operand_decode_stage i_operand_decode_stage (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dst_sel(dst_sel),
    .imm_sel(imm_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_a(op_a), .op_b(op_b), .store_data(store_data), .imm_ext(imm_ext),
    .dst_reg(dst_reg)
  );

  // {instr, dst_sel, imm_sel}
  localparam logic [33:0] VEC [8] = '{
    {32'h0022_8000, 1'b0, 1'b0},
    {32'h03FF_FFFF, 1'b1, 1'b1},
    {32'h0145_7FFF, 1'b1, 1'b0},
    {32'h02B6_8001, 1'b0, 1'b1},
    {32'h0000_1234, 1'b1, 1'b1},
    {32'h03E0_F800, 1'b0, 1'b0},
    {32'h00A5_5A5A, 1'b1, 1'b0},
    {32'h0359_A000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 5'd0) model[a] = d;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] v);
    instr = {6'd0, a, 21'd0};
    #1 v = op_a;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; instr = '0; dst_sel = 0; imm_sel = 0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: all registers clear after reset
    for (int i = 0; i < 32; i++) begin
      read_reg(5'(i), v);
      check("R9 reset value", v, 32'd0);
    end

    // Fill registers with distinct values
    for (int i = 1; i < 32; i++)
      wr(5'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));

    // R7: write to register 0 is dropped
    wr(5'd0, 32'hFFFF_FFFF);
    read_reg(5'd0, v);
    check("R7 reg0 after write", v, 32'd0);
    instr = {6'd0, 5'd0, 5'd0, 16'd0};
    #1 check("R7 reg0 store_data", store_data, 32'd0);

    // R6: disabled write leaves the target alone
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd9; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    read_reg(5'd9, v);
    check("R6 no write when disabled", v, model[9]);

    // R8: same-cycle read sees old value, then new value
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h1357_9BDF;
    instr = {6'd0, 5'd7, 5'd7, 16'd0};
    #1 check("R8 old value before edge", op_a, model[7]);
    check("R8 old store_data before edge", store_data, model[7]);
    @(posedge clk); #1;
    check("R8 new value after edge", op_a, 32'h1357_9BDF);
    model[7] = 32'h1357_9BDF;
    @(negedge clk);
    wr_en = 1'b0;

    // Table of decode vectors: R1 R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      logic [31:0] in; logic ds, is; logic [31:0] ex_imm;
      {in, ds, is} = VEC[k];
      @(negedge clk);
      instr = in; dst_sel = ds; imm_sel = is;
      #1;
      ex_imm = {{16{in[15]}}, in[15:0]};
      check("R1 op_a", op_a, model[in[25:21]]);
      check("R2 store_data", store_data, model[in[20:16]]);
      check("R3 dst_reg", {27'd0, dst_reg}, {27'd0, ds ? in[15:11] : in[20:16]});
      check("R4 imm_ext", imm_ext, ex_imm);
      check("R5 op_b", op_b, is ? ex_imm : model[in[20:16]]);
    end

    // R9: asynchronous clear in the middle of a cycle
    @(negedge clk);
    instr = {6'd0, 5'd31, 5'd30, 16'd0};
    #3 rst_n = 1'b0;
    #1 check("R9 async clear op_a", op_a, 32'd0);
    check("R9 async clear store_data", store_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    read_reg(5'd5, v);
    check("R9 clear after release", v, 32'd0);

    summary();
  end
endmodule